// File: doc/BRIEF.md
# Signaling Control Stream Serializer

This block turns a set of received per-channel signaling nibbles into a serial control stream of 256 bits per frame. The stream has 32 timeslots of 8 bits and runs on a 2.048 MHz bit clock. Each bit comes with its own output-enable, so unused bit positions leave the shared line undriven. The block takes one nibble per channel from an upstream freeze and debounce stage. It places that nibble in the timeslot tied to the channel, in the half of the byte that software selects. It drives nothing elsewhere.

The block has two line modes. In the 24-channel mode every fourth timeslot is left idle. In the 30-channel mode the framing slot and the middle signaling slot stay idle. For two-bit superframe trunks, the last two positions of each nibble carry two software-set filler bits in place of C and D. A stream enable turns the entire output off, so that several devices can share one line. The output enable is forced off while reset is asserted.

Top module: `sig_stream_fmt`

## Requirements
- R1: A bit counter of 256 positions (timeslot = position/8, bit = position%8) restarts when `frame_sync` is sampled high. The position-0 bit appears on the outputs after that same clock edge. Without `frame_sync` the counter wraps from 255 to 0 by itself.
- R2: With `e1_mode` low, channel k (0..23) goes to timeslot k + floor(k/3). Timeslots whose number mod 4 equals 3 are left undriven.
- R3: With `e1_mode` high, channel k goes to timeslot k+1 for k = 0..14 and to timeslot k+2 for k = 15..29. Timeslots 0 and 16 are left undriven.
- R4: With `nib_hi` high, the nibble occupies bits 0..3 of its timeslot, which are the first four bits sent. With `nib_hi` low, it occupies bits 4..7. The other half of the byte is undriven.
- R5: Nibble bits are sent in the order A, B, C, D. Channel k's nibble sits in `sig_nib[4k+3:4k]`, with A at bit 4k+3 and D at bit 4k.
- R6: With `d4_mode` high and `e1_mode` low, the third and fourth nibble bits carry `fill_bits[1]` and then `fill_bits[0]`. With `e1_mode` high, `d4_mode` has no effect.
- R7: Any bit whose edge samples `strm_en` low is undriven (`sig_oe` = 0).
- R8: While `rst_n` is low, `sig_oe` and `sig_dout` are 0.
- R9: `sig_dout` and `sig_oe` are registered on the same edge, and `sig_dout` is 0 whenever `sig_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | Frame start; next bit is position 0 |
| e1_mode | input | 1 | 1 = 30-channel map, 0 = 24-channel map |
| nib_hi | input | 1 | 1 = upper half-byte, 0 = lower half-byte |
| d4_mode | input | 1 | Two-bit superframe trunk (24-channel mode only) |
| fill_bits | input | 2 | Filler for C and D positions in superframe mode |
| strm_en | input | 1 | Stream enable; 0 tristates the whole stream |
| sig_nib | input | 120 | Per-channel ABCD nibbles, channel k at [4k+3:4k] |
| sig_dout | output | 1 | Serial data bit |
| sig_oe | output | 1 | Output enable for the data bit |

## Verification
The bench checks every timeslot of whole frames in both channel maps and both nibble halves. A wrong channel-to-timeslot formula shows up as a driven idle slot, such as slot 3, 16 or 31, or as data from the neighbouring channel. A bench run that restarts the frame partway through and then lets the counter wrap past 255 would catch a counter that fails to realign, or one that stops instead of wrapping. Superframe frames with asymmetric filler values, plus a 30-channel frame with `d4_mode` still high, expose swapped filler bits or filler that leaks into the other mode. A frame with the stream disabled, and a check made during reset, catch an enable that is sampled late or a reset that leaves the pin driven.

// File: rtl/sig_fmt_pkg.sv
package sig_fmt_pkg;

  typedef struct packed {
    logic       valid;
    logic [4:0] chan;
  } slot_map_t;

  // 24-channel map: every fourth slot idle, three channels per group of four
  function automatic slot_map_t t1_slot(input logic [4:0] ts);
    slot_map_t m;
    m.valid = (ts[1:0] != 2'b11);
    m.chan  = {ts[4:2], 1'b0} + {2'b00, ts[4:2]} + {3'b000, ts[1:0]};
    return m;
  endfunction

  // 30-channel map: slot 0 and slot 16 idle
  function automatic slot_map_t e1_slot(input logic [4:0] ts);
    slot_map_t m;
    m.valid = (ts != 5'd0) && (ts != 5'd16);
    m.chan  = (ts < 5'd16) ? ts - 5'd1 : ts - 5'd2;
    return m;
  endfunction

endpackage

// File: rtl/sig_pos_counter.sv
module sig_pos_counter #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_next
);

  assign pos_next = frame_sync ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_next;
  end

  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (pos_q == '0)); // R1
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && (pos_q == '1)) |=> (pos_q == '0)); // R1

endmodule

// File: rtl/sig_slot_decode.sv
module sig_slot_decode
  import sig_fmt_pkg::*;
#(
  parameter int TS_W = 5,
  parameter int CH_W = 5
) (
  input  logic [TS_W-1:0] ts,
  input  logic            e1_mode,
  output logic            valid,
  output logic [CH_W-1:0] chan
);

  slot_map_t m_t1, m_e1, m_sel;

  always_comb begin
    m_t1  = t1_slot(5'(ts));
    m_e1  = e1_slot(5'(ts));
    m_sel = e1_mode ? m_e1 : m_t1;
    valid = m_sel.valid;
    chan  = CH_W'(m_sel.chan);
  end

endmodule

// File: rtl/sig_nibble_pick.sv
module sig_nibble_pick #(
  parameter int NCH   = 30,
  parameter int CH_W  = 5,
  parameter int BIT_W = 3
) (
  input  logic [NCH*4-1:0] sig_nib,
  input  logic [CH_W-1:0]  chan,
  input  logic [BIT_W-1:0] bit_in_ts,
  input  logic             nib_hi,
  input  logic             d4_eff,
  input  logic [1:0]       fill_bits,
  output logic             in_nib,
  output logic             bit_val
);

  localparam int IDX_W = CH_W + 2;

  logic [1:0]       k;
  logic [IDX_W-1:0] idx;
  logic             first_half;

  assign first_half = ~bit_in_ts[BIT_W-1];
  assign k          = bit_in_ts[1:0];
  assign in_nib     = (first_half == nib_hi);
  assign idx        = {chan, ~k};

  always_comb begin
    if (d4_eff && k[1]) bit_val = k[0] ? fill_bits[0] : fill_bits[1];
    else if (idx < IDX_W'(NCH*4)) bit_val = sig_nib[idx];
    else bit_val = 1'b0;
  end

endmodule

// File: rtl/sig_stream_fmt.sv
module sig_stream_fmt #(
  parameter int NCH = 30,
  parameter int NTS = 32,
  parameter int BPT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_sync,
  input  logic           e1_mode,
  input  logic           nib_hi,
  input  logic           d4_mode,
  input  logic [1:0]     fill_bits,
  input  logic           strm_en,
  input  logic [NCH*4-1:0] sig_nib,
  output logic           sig_dout,
  output logic           sig_oe
);

  localparam int BIT_W = $clog2(BPT);
  localparam int TS_W  = $clog2(NTS);
  localparam int POS_W = BIT_W + TS_W;
  localparam int CH_W  = $clog2(NCH);

  logic [POS_W-1:0] pos_q, pos_next;
  logic             slot_valid, in_nib, bit_val, d4_eff;
  logic [CH_W-1:0]  chan;
  logic             oe_next, dout_next;

  sig_pos_counter #(.POS_W(POS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .pos_q(pos_q), .pos_next(pos_next)
  );

  sig_slot_decode #(.TS_W(TS_W), .CH_W(CH_W)) u_dec (
    .ts(pos_next[POS_W-1:BIT_W]), .e1_mode(e1_mode),
    .valid(slot_valid), .chan(chan)
  );

  assign d4_eff = d4_mode & ~e1_mode;

  sig_nibble_pick #(.NCH(NCH), .CH_W(CH_W), .BIT_W(BIT_W)) u_pick (
    .sig_nib(sig_nib), .chan(chan), .bit_in_ts(pos_next[BIT_W-1:0]),
    .nib_hi(nib_hi), .d4_eff(d4_eff), .fill_bits(fill_bits),
    .in_nib(in_nib), .bit_val(bit_val)
  );

  assign oe_next   = strm_en & slot_valid & in_nib;
  assign dout_next = oe_next & bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_oe   <= 1'b0;
      sig_dout <= 1'b0;
    end else begin
      sig_oe   <= oe_next;
      sig_dout <= dout_next;
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strm_en) |-> !sig_oe); // R7
  AST_T1_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(e1_mode) && (pos_q[BIT_W+1:BIT_W] == 2'b11)) |-> !sig_oe); // R2
  AST_E1_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(e1_mode) && ((pos_q[POS_W-1:BIT_W] == '0) ||
     (pos_q[POS_W-1:BIT_W] == TS_W'(16)))) |-> !sig_oe); // R3
  AST_HALF_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sig_oe |-> (pos_q[BIT_W-1] == !$past(nib_hi))); // R4
  AST_D4_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_oe && $past(d4_mode && !e1_mode) && pos_q[1]) |->
    (sig_dout == (pos_q[0] ? $past(fill_bits[0]) : $past(fill_bits[1])))); // R6
  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_oe |-> !sig_dout); // R9
  AST_NIBBLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_oe) |-> (pos_q[1:0] == 2'b00)); // R4

endmodule

// File: tb/tb_sig_stream_fmt.sv
module tb_sig_stream_fmt;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_sync = 1'b0;
  logic         e1_mode = 1'b0, nib_hi = 1'b1, d4_mode = 1'b0, strm_en = 1'b0;
  logic [1:0]   fill_bits = 2'b00;
  logic [119:0] sig_nib = '0;
  logic         sig_dout, sig_oe;

  // requested settings, applied at the next falling edge
  logic         w_e1 = 1'b0, w_hi = 1'b1, w_d4 = 1'b0, w_en = 1'b1;
  logic [1:0]   w_fill = 2'b00;
  logic [119:0] w_nib = '0;

  typedef struct {
    logic  oe;
    logic  d;
    string tag;
    int    pos;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0, n_fail = 0, bp = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  sig_stream_fmt dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .e1_mode(e1_mode),
    .nib_hi(nib_hi), .d4_mode(d4_mode), .fill_bits(fill_bits),
    .strm_en(strm_en), .sig_nib(sig_nib), .sig_dout(sig_dout), .sig_oe(sig_oe)
  );

  function automatic exp_t model(input int p);
    exp_t  e;
    int    ts, b, k, ch;
    bit    ok, hi_half;
    ts = p / 8; b = p % 8; k = b % 4;
    if (e1_mode) begin
      ok = (ts != 0) && (ts != 16);
      ch = (ts < 16) ? ts - 1 : ts - 2;
    end else begin
      ok = (ts % 4) != 3;
      ch = (ts / 4) * 3 + (ts % 4);
    end
    hi_half = (b < 4);
    e.pos = p;
    e.d   = 1'b0;
    if (!strm_en) begin e.oe = 0; e.tag = "R7"; end
    else if (!ok) begin e.oe = 0; e.tag = e1_mode ? "R3" : "R2"; end
    else if (hi_half != nib_hi) begin e.oe = 0; e.tag = "R4"; end
    else begin
      e.oe = 1;
      if (!e1_mode && d4_mode && k >= 2) begin
        e.d = (k == 2) ? fill_bits[1] : fill_bits[0];
        e.tag = "R6";
      end else begin
        e.d = sig_nib[4*ch + 3 - k];
        e.tag = "R5";
      end
    end
    return e;
  endfunction

  task automatic drive_bits(input int n, input bit sync_first);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      e1_mode = w_e1; nib_hi = w_hi; d4_mode = w_d4;
      strm_en = w_en; fill_bits = w_fill; sig_nib = w_nib;
      frame_sync = sync_first && (i == 0);
      bp = frame_sync ? 0 : (bp + 1) % 256;   // R1 restart and wrap
      q.push_back(model(bp));
    end
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  // monitor: compare each produced bit with the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_tests++;
        if (sig_oe !== e.oe || (e.oe && sig_dout !== e.d) || (!e.oe && sig_dout !== 1'b0)) begin
          n_fail++;
          $display("FAIL %s pos=%0d: oe=%b dout=%b expected oe=%b dout=%b (R9 zero when off)",
                   e.tag, e.pos, sig_oe, sig_dout, e.oe, e.d);
        end
      end
    end
  end

  function automatic logic [119:0] pattern(input int seed);
    logic [119:0] v;
    for (int c = 0; c < 30; c++) v[4*c +: 4] = 4'((c * 7 + seed) ^ (c >> 1));
    return v;
  endfunction

  initial begin
    // R8: outputs quiet during reset
    repeat (3) @(negedge clk);
    n_tests++;
    if (sig_oe !== 1'b0 || sig_dout !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset: oe=%b dout=%b expected oe=0 dout=0", sig_oe, sig_dout);
    end
    rst_n = 1'b1;

    // R2 R5: 24-channel map, upper half
    w_nib = pattern(3); w_e1 = 0; w_hi = 1; w_d4 = 0; w_en = 1;
    drive_bits(256, 1);
    // R4: lower half
    w_hi = 0; w_nib = pattern(11);
    drive_bits(256, 1);
    // R6: superframe filler, asymmetric values, both halves
    w_d4 = 1; w_fill = 2'b10; w_hi = 1;
    drive_bits(256, 1);
    w_fill = 2'b01; w_hi = 0;
    drive_bits(256, 1);
    // R3: 30-channel map, d4_mode left high must be ignored (R6)
    w_e1 = 1; w_hi = 1; w_nib = pattern(5); w_fill = 2'b11;
    drive_bits(256, 1);
    w_hi = 0; w_d4 = 0; w_nib = ~pattern(9);
    drive_bits(256, 1);
    // R1: mid-frame restart, then free-running wrap past 255
    w_e1 = 0; w_hi = 1; w_nib = pattern(1);
    drive_bits(37, 1);
    drive_bits(400, 1);
    // R7: stream disabled for a frame, then re-enabled
    w_en = 0;
    drive_bits(256, 1);
    w_en = 1; w_e1 = 1; w_nib = '1;
    drive_bits(256, 1);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule